// File: doc/BRIEF.md
# Rotate Then Mask Unit

This unit rotates a data word left, builds a run of ones from a start position to a stop position, and combines the two. A shift-and-field datapath uses it to extract bit fields, to clear ranges of bits, and to deposit a field into an existing word. The rotate amount comes from an immediate field or from the low bits of a register operand. A rotate to the right by `n` is requested as a left rotate by `W - n`.

The mask uses MSB-0 numbering: position 0 is the most significant bit of the word. When the start position is greater than the stop position, the run of ones wraps past the end of the word and continues from position 0. In clear mode the output is the rotated word ANDed with the mask. In deposit mode the output takes the rotated bits where the mask is one and keeps the old destination bits where the mask is zero. An optional flag request compares the result, read as a signed number, with zero.

The datapath is combinational. With the default `REG_OUT = 1`, one register stage sits at the output. The checker and the bench are written for that registered variant.

Top module: `rotmask_unit`

## Requirements
- R1: With `amt_sel_i = 0`, the word is rotated left by `amt_imm_i` before masking.
- R2: With `amt_sel_i = 1`, the rotate count is `amt_reg_i` modulo W, so only its low log2(W) bits are used. The upper bits of `amt_reg_i` have no effect on the result.
- R3: When `mstart_i <= mstop_i`, the mask has ones at MSB-0 positions `mstart_i` through `mstop_i` inclusive, where MSB-0 position p is vector bit W-1-p. All other mask bits are zero.
- R4: When `mstart_i > mstop_i`, the mask has ones at positions `mstart_i`..W-1 and at positions 0..`mstop_i`. All other mask bits are zero.
- R5: With `deposit_i = 0`, the result is the rotated word ANDed with the mask. A count of 0 gives plain masking of the source.
- R6: With `deposit_i = 1`, the result is (rotated AND mask) OR (`dst_i` AND NOT mask).
- R7: With `flags_en_i = 1`, `lt_o`, `gt_o` and `eq_o` give a signed comparison of the result with zero. Exactly one of them is 1.
- R8: With `flags_en_i = 0`, `lt_o`, `gt_o` and `eq_o` are all 0.
- R9: The result and the flags appear one clock after the inputs are sampled. While `rst_n` is low they are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| src_i | input | W | Word to rotate |
| dst_i | input | W | Old destination word, used in deposit mode |
| amt_imm_i | input | log2(W) | Immediate rotate count |
| amt_reg_i | input | W | Register rotate count; only the low bits are used |
| amt_sel_i | input | 1 | 0 selects the immediate count, 1 selects the register count |
| mstart_i | input | log2(W) | MSB-0 position where the run of ones starts |
| mstop_i | input | log2(W) | MSB-0 position where the run of ones stops |
| deposit_i | input | 1 | 0 selects clear mode, 1 selects deposit mode |
| flags_en_i | input | 1 | Request for the compare-with-zero flags |
| result_o | output | W | Registered result |
| lt_o | output | 1 | Result is negative |
| gt_o | output | 1 | Result is positive |
| eq_o | output | 1 | Result is zero |

## Verification
The bench targets several corner cases:
- Start equal to stop gives a single-bit mask. A design with an off-by-one in the range check would produce zero bits or two bits instead of one.
- Start one past stop gives a full wrapped mask. A design that compared with the wrong sense would give an empty mask or a narrow mask in this case.
- Register counts with upper bits set would make a design that used the whole register rotate by the wrong amount.
- Deposit cases with a destination of all ones would show a design that drops the old bits or inverts the mask.
- Results of 0x80000000 and zero check the flags. A design that compared unsigned would report a large positive value there instead of a negative one.
- Directed cases are followed by a long run of pseudo-random vectors, all compared with a behavioural model.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

   typedef enum logic {
      MODE_CLEAR   = 1'b0,
      MODE_DEPOSIT = 1'b1
   } rm_mode_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
   } rm_flags_t;

endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
   parameter int W   = 32,
   parameter int SHW = $clog2(W)
) (
   input  logic [W-1:0]   data_i,
   input  logic [SHW-1:0] amt_i,
   output logic [W-1:0]   data_o
);

   logic [W-1:0] stage [0:SHW];

   assign stage[0] = data_i;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int STEP = 2 ** k;
      logic [W-1:0] turned;
      assign turned       = (stage[k] << STEP) | (stage[k] >> (W - STEP));
      assign stage[k + 1] = amt_i[k] ? turned : stage[k];
   end

   assign data_o = stage[SHW];

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
   parameter int W   = 32,
   parameter int SHW = $clog2(W)
) (
   input  logic [SHW-1:0] start_i,
   input  logic [SHW-1:0] stop_i,
   output logic [W-1:0]   mask_o
);

   logic wraps;
   assign wraps = start_i > stop_i;

   for (genvar j = 0; j < W; j++) begin : g_bit
      localparam logic [SHW-1:0] POS = SHW'(W - 1 - j);
      logic at_or_after_start;
      logic at_or_before_stop;
      assign at_or_after_start = POS >= start_i;
      assign at_or_before_stop = POS <= stop_i;
      assign mask_o[j] = wraps ? (at_or_after_start | at_or_before_stop)
                               : (at_or_after_start & at_or_before_stop);
   end

endmodule

// File: rtl/rotmask_merge.sv
module rotmask_merge
   import rotmask_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] rot_i,
   input  logic [W-1:0] mask_i,
   input  logic [W-1:0] dst_i,
   input  rm_mode_e     mode_i,
   input  logic         flags_en_i,
   output logic [W-1:0] res_o,
   output rm_flags_t    flags_o
);

   logic [W-1:0] kept;
   logic         is_zero;
   logic         is_neg;

   always_comb begin
      kept  = (mode_i == MODE_DEPOSIT) ? (dst_i & ~mask_i) : '0;
      res_o = (rot_i & mask_i) | kept;
   end

   assign is_zero = (res_o == '0);
   assign is_neg  = res_o[W-1];

   always_comb begin
      flags_o = '0;
      if (flags_en_i) begin
         flags_o.lt = is_neg;
         flags_o.eq = is_zero;
         flags_o.gt = ~is_neg & ~is_zero;
      end
   end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
   import rotmask_pkg::*;
#(
   parameter int W       = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int SHW    = $clog2(W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   src_i,
   input  logic [W-1:0]   dst_i,
   input  logic [SHW-1:0] amt_imm_i,
   input  logic [W-1:0]   amt_reg_i,
   input  logic           amt_sel_i,
   input  logic [SHW-1:0] mstart_i,
   input  logic [SHW-1:0] mstop_i,
   input  logic           deposit_i,
   input  logic           flags_en_i,
   output logic [W-1:0]   result_o,
   output logic           lt_o,
   output logic           gt_o,
   output logic           eq_o
);

   if (W < 8 || (2 ** SHW) != W) begin : g_bad_width
      initial $error("rotmask_unit: W must be a power of two, at least 8");
   end

   logic [SHW-1:0] amt;
   logic [W-1:0]   rotated;
   logic [W-1:0]   mask;
   logic [W-1:0]   res_c;
   rm_flags_t      flags_c;
   rm_mode_e       mode;

   assign amt  = amt_sel_i ? amt_reg_i[SHW-1:0] : amt_imm_i;
   assign mode = deposit_i ? MODE_DEPOSIT : MODE_CLEAR;

   rotmask_rotator #(.W(W), .SHW(SHW)) u_rot (
      .data_i (src_i),
      .amt_i  (amt),
      .data_o (rotated)
   );

   rotmask_maskgen #(.W(W), .SHW(SHW)) u_mask (
      .start_i (mstart_i),
      .stop_i  (mstop_i),
      .mask_o  (mask)
   );

   rotmask_merge #(.W(W)) u_merge (
      .rot_i      (rotated),
      .mask_i     (mask),
      .dst_i      (dst_i),
      .mode_i     (mode),
      .flags_en_i (flags_en_i),
      .res_o      (res_c),
      .flags_o    (flags_c)
   );

   if (REG_OUT) begin : g_reg
      rm_flags_t flags_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result_o <= '0;
            flags_q  <= '0;
         end else begin
            result_o <= res_c;
            flags_q  <= flags_c;
         end
      end
      assign lt_o = flags_q.lt;
      assign gt_o = flags_q.gt;
      assign eq_o = flags_q.eq;
   end else begin : g_comb
      assign result_o = res_c;
      assign lt_o     = flags_c.lt;
      assign gt_o     = flags_c.gt;
      assign eq_o     = flags_c.eq;
   end

endmodule

// File: rtl/rotmask_checker.sv
module rotmask_checker #(
   parameter int W       = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int SHW    = $clog2(W)
) (
   input logic           clk,
   input logic           rst_n,
   input logic [W-1:0]   src_i,
   input logic [W-1:0]   amt_reg_i,
   input logic           amt_sel_i,
   input logic [SHW-1:0] mstart_i,
   input logic [SHW-1:0] mstop_i,
   input logic           deposit_i,
   input logic           flags_en_i,
   input logic [W-1:0]   result_o,
   input logic           lt_o,
   input logic           gt_o,
   input logic           eq_o
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   if (REG_OUT) begin : g_props
      // R7: one flag when requested
      a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(flags_en_i)) |-> ($countones({lt_o, gt_o, eq_o}) == 1));

      // R7: eq only for zero result, lt only for negative result
      a_r7_eq_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && eq_o) |-> (result_o == '0));

      a_r7_lt_means_sign: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && lt_o) |-> result_o[W-1]);

      // R8: no flags without request
      a_r8_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && !$past(flags_en_i)) |-> ({lt_o, gt_o, eq_o} == 3'b000));

      // R5 with R3: single top-bit mask in clear mode leaves other bits zero
      a_r5_clear_outside: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && !$past(deposit_i) && $past(mstart_i) == '0 && $past(mstop_i) == '0)
         |-> (result_o[W-2:0] == '0));

      // R2: register count that is a multiple of W with full mask passes source
      a_r2_count_mod: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(amt_sel_i) && ($past(amt_reg_i) % W) == 0 && !$past(deposit_i)
          && $past(mstart_i) == '0 && $past(mstop_i) == SHW'(W - 1))
         |-> (result_o == $past(src_i)));
   end

endmodule

bind rotmask_unit rotmask_checker #(.W(W), .REG_OUT(REG_OUT)) u_rotmask_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_i      (src_i),
   .amt_reg_i  (amt_reg_i),
   .amt_sel_i  (amt_sel_i),
   .mstart_i   (mstart_i),
   .mstop_i    (mstop_i),
   .deposit_i  (deposit_i),
   .flags_en_i (flags_en_i),
   .result_o   (result_o),
   .lt_o       (lt_o),
   .gt_o       (gt_o),
   .eq_o       (eq_o)
);

// File: tb/tb_rotmask_unit.sv
`timescale 1ns/1ps
module tb_rotmask_unit;

   localparam int W   = 32;
   localparam int SHW = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [W-1:0]   src_i = '0, dst_i = '0, amt_reg_i = '0;
   logic [SHW-1:0] amt_imm_i = '0, mstart_i = '0, mstop_i = '0;
   logic           amt_sel_i = 1'b0, deposit_i = 1'b0, flags_en_i = 1'b0;
   logic [W-1:0]   result_o;
   logic           lt_o, gt_o, eq_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   rotmask_unit #(.W(W), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .dst_i(dst_i),
      .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i), .amt_sel_i(amt_sel_i),
      .mstart_i(mstart_i), .mstop_i(mstop_i), .deposit_i(deposit_i),
      .flags_en_i(flags_en_i), .result_o(result_o),
      .lt_o(lt_o), .gt_o(gt_o), .eq_o(eq_o)
   );

   function automatic logic [W-1:0] ref_mask(int s, int e);
      logic [W-1:0] m = '0;
      for (int p = 0; p < W; p++) begin
         bit on = (s <= e) ? (p >= s && p <= e) : (p >= s || p <= e);
         if (on) m[W-1-p] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [W-1:0] ref_rot(logic [W-1:0] x, int n);
      logic [W-1:0] r = x;
      for (int i = 0; i < n; i++) r = {r[W-2:0], r[W-1]};
      return r;
   endfunction

   task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive at negedge, compare one negedge later (one register stage)
   task automatic apply(string tag, logic [W-1:0] s, logic [W-1:0] d,
                        logic sel, int imm, logic [W-1:0] rg,
                        int ms, int me, logic dep, logic fl);
      logic [W-1:0] rot, m, exp;
      int n;
      logic [2:0] eflags;
      @(negedge clk);
      src_i = s; dst_i = d; amt_sel_i = sel; amt_imm_i = SHW'(imm);
      amt_reg_i = rg; mstart_i = SHW'(ms); mstop_i = SHW'(me);
      deposit_i = dep; flags_en_i = fl;
      n   = sel ? int'(rg % W) : imm;
      rot = ref_rot(s, n);
      m   = ref_mask(ms, me);
      exp = dep ? ((rot & m) | (d & ~m)) : (rot & m);
      if (!fl)                    eflags = 3'b000;
      else if ($signed(exp) < 0)  eflags = 3'b100;
      else if ($signed(exp) > 0)  eflags = 3'b010;
      else                        eflags = 3'b001;
      @(negedge clk);
      check(tag, result_o, exp);
      check({tag, " flags"}, {29'd0, lt_o, gt_o, eq_o}, {29'd0, eflags});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) cycles++;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 reset result", result_o, '0);
      check("R9 reset flags", {29'd0, lt_o, gt_o, eq_o}, '0);
      rst_n = 1'b1;

      apply("R1 imm rotate 8 full mask", 32'h1234_5678, '0, 0, 8, '0, 0, 31, 0, 0);
      apply("R1 imm rotate 31", 32'h8000_0001, '0, 0, 31, '0, 0, 31, 0, 0);
      apply("R2 reg count upper bits ignored", 32'hA5A5_0F0F, '0, 1, 0, 32'hFFFF_FF24, 0, 31, 0, 0);
      apply("R2 reg count 32 acts as zero", 32'hDEAD_BEEF, '0, 1, 0, 32'h0000_0020, 0, 31, 0, 0);
      apply("R3 single bit mask", 32'hFFFF_FFFF, '0, 0, 0, '0, 7, 7, 0, 0);
      apply("R3 middle field", 32'hFFFF_FFFF, '0, 0, 0, '0, 16, 23, 0, 0);
      apply("R4 wrap mask", 32'hFFFF_FFFF, '0, 0, 0, '0, 28, 3, 0, 0);
      apply("R4 wrap full mask", 32'h0F1E_2D3C, '0, 0, 0, '0, 5, 4, 0, 0);
      apply("R5 count zero plain mask", 32'h1357_9BDF, '0, 0, 0, '0, 24, 31, 0, 0);
      apply("R5 extract field", 32'hABCD_1234, '0, 0, 12, '0, 24, 31, 0, 0);
      apply("R6 deposit keeps dst", 32'h0000_00AB, 32'hFFFF_FFFF, 0, 16, '0, 8, 15, 1, 0);
      apply("R6 deposit wrap", 32'h1234_5678, 32'h0, 0, 4, '0, 30, 1, 1, 0);
      apply("R7 negative flag", 32'h0000_0001, '0, 0, 31, '0, 0, 31, 0, 1);
      apply("R7 positive flag", 32'h0000_0001, '0, 0, 0, '0, 0, 31, 0, 1);
      apply("R7 zero flag", 32'hFFFF_0000, '0, 0, 0, '0, 16, 31, 0, 1);
      apply("R8 flags off", 32'h8000_0000, '0, 0, 0, '0, 0, 31, 0, 0);

      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] s = $urandom, d = $urandom, rg = $urandom;
         apply((i % 2) ? "R6 random" : "R5 random", s, d, $urandom_range(0, 1),
               $urandom_range(0, 31), rg, $urandom_range(0, 31),
               $urandom_range(0, 31), i[0], $urandom_range(0, 1));
      end

      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset again result", result_o, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule